// File: doc/BRIEF.md
# Programmable Rate and Square-Wave Counter Channel

This block is one channel of a programmable binary down-counter. A host writes one byte per cycle through a small write port. A control byte selects the waveform and halts the channel. A count byte supplies the low byte of the period length, and the upper byte is taken as zero. The channel then produces a periodic waveform on `out_wave`. In rate mode this is one low cycle per period. In square mode it is an almost symmetric square wave.

A level-sensitive `gate` input pauses counting while it is low and forces the output high. A rising edge on `gate` is a trigger. It restarts the period from the most recently written count, so external hardware can align the waveform. A count written while the channel is running does not disturb the current period. The new count takes effect at the next natural reload, or earlier if a trigger arrives first. All activity, including host writes, is synchronous to `clk`.

Top module: `rsq_counter_ch`

## Requirements
- R1: After reset the channel is idle and `out_wave` is high.
- R2: A control write (`wr_en`=1, `wr_is_ctrl`=1) stops the channel, and `out_wave` stays high until a count is written and loaded. Bit 1 of the control byte selects square mode (1) or rate mode (0). All other control bits are ignored.
- R3: A count write (`wr_en`=1, `wr_is_ctrl`=0) to an idle channel is loaded on the clock edge after the write edge, not at the write itself. Counting the write edge as edge 0, the waveform phase after edge k (k >= 1) is p = (k-1) mod N.
- R4: In rate mode with `gate` held high, `out_wave` is low exactly when p = N-1. This is one clock in every N clocks.
- R5: While `gate` is low, counting is suspended and `out_wave` is high. This takes effect in the same cycle that `gate` falls, with no clock edge needed. No low pulse appears however long `gate` stays low.
- R6: A `gate` rising edge is sampled at edge t0 and reloads the count at edge t0+1. The waveform then follows the R3 phase rule with t0 in place of the write edge, and `out_wave` stays high until the reload.
- R7: A count written while the channel runs leaves the current period unchanged. The new N applies from the next terminal reload.
- R8: A trigger that follows a mid-period count write starts the new N immediately, per R6.
- R9: In square mode `out_wave` is high for p < ceil(N/2) and low otherwise. For odd N this is (N+1)/2 high cycles and (N-1)/2 low cycles.
- R10: A count byte of 0 means N = 256. In rate mode a count byte of 1 behaves as N = 2. In square mode a count byte of 1 gives a constant high output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counting clock; all registers use its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Host write strobe, one byte per asserted cycle |
| wr_is_ctrl | input | 1 | 1 selects the control byte, 0 selects the count byte |
| wr_data | input | 8 | Host write data |
| gate | input | 1 | Count enable (level) and trigger (rising edge) |
| out_wave | output | 1 | Periodic output waveform |

## Verification
The bench aims at the places where the period boundary is easy to misplace. It tests the one-edge delay between a write or trigger and the load, where an early load shifts every pulse by a cycle. It tests odd square-wave counts, where a wrong half split swaps the high and low lengths. It tests the count values 1 and 0, where a missing clamp or wrap gives a stuck output or a period of zero. It also tests a mid-period rewrite with and without a following trigger, where a design that reloads at once would shorten the running period, and one that ignores the trigger would keep the stale length. Finally, it holds `gate` low during a low pulse and well past the point where a pulse would fall due, to expose any output that is not forced high or any counter that does not freeze.

// File: rtl/rsq_pkg.sv
package rsq_pkg;
  // Waveform selection held by the control register.
  typedef enum logic {
    WAVE_RATE   = 1'b0,
    WAVE_SQUARE = 1'b1
  } wave_mode_e;
endpackage

// File: rtl/rsq_host_regs.sv
module rsq_host_regs
  import rsq_pkg::*;
#(
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned MODE_BIT = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_is_ctrl,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              running,
  input  logic              load_ack,
  output logic              ctrl_wr,
  output logic              cnt_wr,
  output wave_mode_e        mode,
  output logic [DATA_W-1:0] init_lsb,
  output logic              load_pend
);
  // Decoded write events, exposed for the counter core and checker.
  assign ctrl_wr = wr_en &  wr_is_ctrl;
  assign cnt_wr  = wr_en & ~wr_is_ctrl;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode      <= WAVE_RATE;
      init_lsb  <= '0;
      load_pend <= 1'b0;
    end else if (ctrl_wr) begin
      mode      <= wave_mode_e'(wr_data[MODE_BIT]);
      load_pend <= 1'b0;
    end else begin
      if (cnt_wr) begin
        init_lsb <= wr_data;
      end
      // An idle channel loads on the following edge; a running one
      // keeps the value for its next reload.
      if (cnt_wr && !running) begin
        load_pend <= 1'b1;
      end else if (load_ack) begin
        load_pend <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/rsq_gate_trig.sv
module rsq_gate_trig (
  input  logic clk,
  input  logic rst_n,
  input  logic gate,
  input  logic ctrl_wr,
  output logic gate_rise,
  output logic gate_run,
  output logic trig_pend
);
  logic gate_q;

  // Edge seen at this clock; acted upon one clock later.
  assign gate_rise = gate & ~gate_q;
  // Counting is allowed only once gate has been high for a full sample.
  assign gate_run  = gate & gate_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gate_q    <= 1'b0;
      trig_pend <= 1'b0;
    end else begin
      gate_q    <= gate;
      trig_pend <= gate_rise & ~ctrl_wr;
    end
  end
endmodule

// File: rtl/rsq_down_core.sv
module rsq_down_core #(
  parameter int unsigned CW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ctrl_wr,
  input  logic          load_now,
  input  logic          count_en,
  input  logic [CW-1:0] reload_val,
  output logic [CW-1:0] cnt,
  output logic [CW-1:0] cur_n,
  output logic          running,
  output logic          term_evt
);
  localparam logic [CW-1:0] ONE = CW'(1);

  // Terminal point of a period: reload rather than decrement.
  assign term_evt = running & count_en & (cnt <= ONE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt     <= '0;
      cur_n   <= '0;
      running <= 1'b0;
    end else if (ctrl_wr) begin
      cnt     <= '0;
      running <= 1'b0;
    end else if (load_now || term_evt) begin
      cnt     <= reload_val;
      cur_n   <= reload_val;
      running <= 1'b1;
    end else if (running && count_en) begin
      cnt <= cnt - ONE;
    end
  end
endmodule

// File: rtl/rsq_wave_out.sv
module rsq_wave_out
  import rsq_pkg::*;
#(
  parameter int unsigned CW = 9
) (
  input  logic          running,
  input  wave_mode_e    mode,
  input  logic          gate,
  input  logic          gate_run,
  input  logic          trig_pend,
  input  logic [CW-1:0] cnt,
  input  logic [CW-1:0] cur_n,
  output logic          out_wave
);
  // Square wave: the lower half of the remaining count is the low phase.
  function automatic logic sq_in_low(input logic [CW-1:0] c, input logic [CW-1:0] n);
    return c <= (n >> 1);
  endfunction

  logic phase_low;
  logic allow_low;

  always_comb begin
    if (mode == WAVE_RATE) phase_low = (cnt == CW'(1));
    else                   phase_low = sq_in_low(cnt, cur_n);
  end

  // Low output needs a running channel, a settled gate and no pending
  // trigger reload; a falling gate releases the output combinationally.
  assign allow_low = running & gate & gate_run & ~trig_pend;
  assign out_wave  = ~(allow_low & phase_low);
endmodule

// File: rtl/rsq_counter_ch.sv
module rsq_counter_ch
  import rsq_pkg::*;
#(
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned MODE_BIT = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_is_ctrl,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              gate,
  output logic              out_wave
);
  localparam int unsigned CW = DATA_W + 1;

  // Effective period from the written byte: 0 wraps to full range, and
  // rate mode cannot run with a period of one.
  function automatic logic [CW-1:0] eff_count(input logic [DATA_W-1:0] lsb,
                                               input wave_mode_e m);
    logic [CW-1:0] v;
    v = {1'b0, lsb};
    if (lsb == '0)                          v = CW'(1) << DATA_W;
    else if (m == WAVE_RATE && v == CW'(1)) v = CW'(2);
    return v;
  endfunction

  wave_mode_e        mode_q;
  logic [DATA_W-1:0] init_lsb;
  logic              load_pend;
  logic              ctrl_wr;
  logic              cnt_wr;
  logic              gate_rise;
  logic              gate_run;
  logic              trig_pend;
  logic [CW-1:0]     cnt_q;
  logic [CW-1:0]     cur_n_q;
  logic              running_q;
  logic              term_evt;
  logic              load_now;
  logic [CW-1:0]     reload_val;

  assign load_now   = load_pend | (trig_pend & running_q);
  assign reload_val = eff_count(init_lsb, mode_q);

  rsq_host_regs #(.DATA_W(DATA_W), .MODE_BIT(MODE_BIT)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_is_ctrl (wr_is_ctrl),
    .wr_data    (wr_data),
    .running    (running_q),
    .load_ack   (load_now),
    .ctrl_wr    (ctrl_wr),
    .cnt_wr     (cnt_wr),
    .mode       (mode_q),
    .init_lsb   (init_lsb),
    .load_pend  (load_pend)
  );

  rsq_gate_trig u_gate (
    .clk       (clk),
    .rst_n     (rst_n),
    .gate      (gate),
    .ctrl_wr   (ctrl_wr),
    .gate_rise (gate_rise),
    .gate_run  (gate_run),
    .trig_pend (trig_pend)
  );

  rsq_down_core #(.CW(CW)) u_core (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctrl_wr    (ctrl_wr),
    .load_now   (load_now),
    .count_en   (gate_run),
    .reload_val (reload_val),
    .cnt        (cnt_q),
    .cur_n      (cur_n_q),
    .running    (running_q),
    .term_evt   (term_evt)
  );

  rsq_wave_out #(.CW(CW)) u_out (
    .running   (running_q),
    .mode      (mode_q),
    .gate      (gate),
    .gate_run  (gate_run),
    .trig_pend (trig_pend),
    .cnt       (cnt_q),
    .cur_n     (cur_n_q),
    .out_wave  (out_wave)
  );
endmodule

// File: rtl/rsq_counter_ch_chk.sv
module rsq_counter_ch_chk #(
  parameter int unsigned CW = 9
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ctrl_wr,
  input logic          gate,
  input logic          out_wave,
  input logic          running,
  input logic          load_now,
  input logic          mode_sq,
  input logic [CW-1:0] cnt,
  input logic [CW-1:0] cur_n
);
  p_idle_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !running |-> out_wave);

  p_ctrl_stops_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr |=> !running);

  p_gate_low_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !gate |-> out_wave);

  p_freeze_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (running && !gate && !load_now && !ctrl_wr) |=> (cnt == $past(cnt)));

  p_single_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (running && !mode_sq && !out_wave) |=> out_wave);

  p_cnt_range_r10: assert property (@(posedge clk) disable iff (!rst_n)
    running |-> (cnt != '0 && cnt <= cur_n));

  p_rate_min_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (running && !mode_sq) |-> (cur_n >= CW'(2)));
endmodule

bind rsq_counter_ch rsq_counter_ch_chk #(.CW(CW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .ctrl_wr  (ctrl_wr),
  .gate     (gate),
  .out_wave (out_wave),
  .running  (running_q),
  .load_now (load_now),
  .mode_sq  (mode_q == rsq_pkg::WAVE_SQUARE),
  .cnt      (cnt_q),
  .cur_n    (cur_n_q)
);

// File: tb/rsq_counter_ch_bench.sv
`timescale 1ns/1ps
module rsq_counter_ch_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic       wr_is_ctrl = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       gate = 1'b1;
  logic       out_wave;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  rsq_counter_ch u_rsq_counter_ch (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_is_ctrl(wr_is_ctrl),
    .wr_data(wr_data), .gate(gate), .out_wave(out_wave)
  );

  // Period implied by a count byte.
  function automatic int eff_n(int lsb, bit sq);
    int v = (lsb == 0) ? 256 : lsb;
    if (!sq && v == 1) v = 2;
    return v;
  endfunction

  // Expected level k edges after a write or trigger edge (k >= 1).
  function automatic bit exp_out(int n, bit sq, int k);
    int p = (k - 1) % n;
    if (sq) return p < (n + 1) / 2;
    return p != n - 1;
  endfunction

  task automatic check(bit act, bit exp, string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: out_wave=%0b expected %0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic wr(bit ctrl, logic [7:0] d);
    wr_en = 1'b1; wr_is_ctrl = ctrl; wr_data = d;
    step();
    wr_en = 1'b0; wr_is_ctrl = 1'b0;
  endtask

  task automatic run_expect(int n, bit sq, int k0, int k1, string req);
    for (int k = k0; k <= k1; k++) begin
      step();
      check(out_wave, exp_out(n, sq, k), req);
    end
  endtask

  task automatic run_high(int cnt, string req);
    for (int i = 0; i < cnt; i++) begin
      step();
      check(out_wave, 1'b1, req);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    checks++; errors++;
    $display("FAIL watchdog: run did not complete, actual=hung expected=done");
    finish_run();
  end

  initial begin
    void'($urandom(32'h1c0ffee));
    repeat (3) step();
    rst_n = 1'b1;
    step();
    check(out_wave, 1'b1, "R1");
    run_high(3, "R1");

    // R3/R4: rate mode, N=4.
    wr(1'b1, 8'h00);
    check(out_wave, 1'b1, "R2");
    wr(1'b0, 8'd4);
    check(out_wave, 1'b1, "R3");
    run_expect(4, 1'b0, 1, 12, "R4");

    // R2: control write halts, then square mode selected by bit 1.
    wr(1'b1, 8'h02);
    run_high(20, "R2");
    wr(1'b0, 8'd5);
    run_expect(5, 1'b1, 1, 15, "R9");

    // R2: other control bits ignored, bit 1 clear means rate.
    wr(1'b1, 8'hFD);
    wr(1'b0, 8'd3);
    run_expect(3, 1'b0, 1, 9, "R2");

    // R5/R6: gate drop during the pulse, long freeze, then trigger.
    wr(1'b1, 8'h00);
    wr(1'b0, 8'd5);
    run_expect(5, 1'b0, 1, 5, "R4");
    gate = 1'b0;
    #1;
    check(out_wave, 1'b1, "R5");
    run_high(12, "R5");
    gate = 1'b1;
    step();
    check(out_wave, 1'b1, "R6");
    run_expect(5, 1'b0, 1, 10, "R6");

    // R7: rewrite mid-period, new length only after the next reload.
    wr(1'b1, 8'h00);
    wr(1'b0, 8'd6);
    run_expect(6, 1'b0, 1, 3, "R7");
    wr(1'b0, 8'd3);
    check(out_wave, exp_out(6, 1'b0, 4), "R7");
    run_expect(6, 1'b0, 5, 6, "R7");
    for (int k = 7; k <= 15; k++) begin
      step();
      check(out_wave, exp_out(3, 1'b0, k - 6), "R7");
    end

    // R8: rewrite then trigger, new length starts from the trigger.
    wr(1'b1, 8'h00);
    wr(1'b0, 8'd6);
    run_expect(6, 1'b0, 1, 3, "R8");
    wr(1'b0, 8'd3);
    gate = 1'b0;
    step();
    check(out_wave, 1'b1, "R8");
    gate = 1'b1;
    step();
    check(out_wave, 1'b1, "R8");
    run_expect(3, 1'b0, 1, 9, "R8");

    // R10: small and wrapped counts.
    wr(1'b1, 8'h00);
    wr(1'b0, 8'd1);
    run_expect(eff_n(1, 1'b0), 1'b0, 1, 8, "R10");
    wr(1'b1, 8'h02);
    wr(1'b0, 8'd1);
    run_high(6, "R10");
    wr(1'b1, 8'h00);
    wr(1'b0, 8'd0);
    run_expect(eff_n(0, 1'b0), 1'b0, 1, 512, "R10");
    wr(1'b1, 8'h02);
    wr(1'b0, 8'd0);
    run_expect(eff_n(0, 1'b1), 1'b1, 1, 256, "R10");

    // Random modes and counts, including odd square lengths.
    for (int t = 0; t < 24; t++) begin
      bit sq = 1'($urandom_range(0, 1));
      int lsb = int'($urandom_range(2, 40));
      int n = eff_n(lsb, sq);
      wr(1'b1, sq ? 8'h02 : 8'h00);
      wr(1'b0, 8'(lsb));
      run_expect(n, sq, 1, 2 * n, sq ? "R9" : "R4");
    end

    finish_run();
  end
endmodule